// File: doc/BRIEF.md
# Virtual Address Translation and Fault Classifier

This block is the translation front end of a memory-management unit. One request per cycle carries a 64-bit virtual address, the stream it comes from (instruction fetch or data), the direction of a data access, the current privilege mode, two superpage enables and the answer of an external TLB lookup (hit flag, page frame number and protection word). One cycle later the block returns either a physical address or a fault code with a stream tag.

The address is checked first: its bits above the implemented 43-bit range must all be equal to each other. A valid address that falls in an enabled 43-bit or 32-bit superpage window is translated by masking, with no use of the TLB result, and only kernel mode may use those windows. Any other address needs a TLB hit. The physical address is then the frame number joined to the 13-bit page offset. Before that address is given out, the block checks the protection word for the required permission bits and turns any missing bits into one of three fault codes, in a fixed order of priority.

Top module: `xlate_unit`

## Requirements
- R1: After reset and until the first request, rsp_valid, rsp_fault, rsp_tag and rsp_pa are all zero.
- R2: rsp_valid is high in the cycle after a cycle with req_valid high and low otherwise. All response fields belong to that earlier request.
- R3: If bits 63..43 of the address are neither all zeros nor all ones, the fault is bad-address (code 1). This check comes before every other check.
- R4: With sp43_en high and address bits 42..41 equal to 2, in kernel mode (mode 0), rsp_pa equals address bits 42..0 and tlb_hit is ignored. With sp43_en low the address goes through the TLB path.
- R5: With sp32_en high and address bits 42..30 equal to 0x1FFE, in kernel mode, rsp_pa equals address bits 29..0 zero-extended, whatever the TLB result.
- R6: A request that lands in an enabled superpage window in a mode other than kernel gets access-violation (code 2).
- R7: Outside the superpage windows, a request with tlb_hit low gets TB-miss (code 3).
- R8: On a hit with every required bit present, rsp_pa is {tlb_pfn, address bits 12..0} and rsp_fault is 0.
- R9: Protection word layout: bit 0 valid, bit 1 read-permit, bit 2 write-permit, bit 3 execute-permit (the permit bits are active-low fault-on flags), bits 8+m read enable and bits 12+m write enable for mode m (0 kernel, 1 executive, 2 supervisor, 3 user). A read or a fetch needs valid, its permit bit and the read enable of the mode. A write needs valid, write-permit and the write enable of the mode. A missing mode enable gives access-violation (code 2), whatever the other bits hold.
- R10: With the mode enable present and a required permit bit clear, the fault is fault-on (code 4), whatever the valid bit holds.
- R11: With only the valid bit missing, the fault is translation-not-valid (code 5).
- R12: With a fault, rsp_tag is 3 for instruction requests, 2 for data writes and 1 for data reads, and rsp_pa is 0. With no fault, rsp_tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | Data access is a write (ignored for fetches) |
| req_mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| sp43_en | input | 1 | Enable the 43-bit superpage window |
| sp32_en | input | 1 | Enable the 32-bit superpage window |
| tlb_hit | input | 1 | TLB lookup found an entry |
| tlb_pfn | input | 30 | Page frame number of the hit entry |
| tlb_pte | input | 16 | Protection word of the hit entry |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 43 | Physical address (0 on a fault) |
| rsp_fault | output | 3 | 0 none, 1 bad address, 2 access violation, 3 TB miss, 4 fault-on, 5 not valid |
| rsp_tag | output | 2 | Fault stream tag: 0 none, 1 read, 2 write, 3 execute |

## Verification
The block has no state that lasts beyond one request. A wrong decision in the address decoder or the permission classifier therefore shows up in the single response to the request that caused it, one cycle after that request. Wrong priority between the checks shows up as the wrong fault code when the request carries several faulty conditions at once. A corrupted response register shows up as fields that do not match their request, or as rsp_valid out of step with req_valid. The reference model is therefore compared with every response field on every cycle, with directed requests that layer several faults together and a long run of biased random requests.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int PTE_W = 16;

  // protection word bit positions
  localparam int B_VALID = 0;
  localparam int B_ROK   = 1;
  localparam int B_WOK   = 2;
  localparam int B_XOK   = 3;
  localparam int B_RE0   = 8;
  localparam int B_WE0   = 12;

  localparam logic [PTE_W-1:0] PERMIT_MASK = 16'h000E;
  localparam logic [PTE_W-1:0] SPECIAL_MASK = 16'h000F;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_BVA  = 3'd1,
    FLT_ACV  = 3'd2,
    FLT_TBM  = 3'd3,
    FLT_FOX  = 3'd4,
    FLT_TNV  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    TAG_NONE  = 2'd0,
    TAG_READ  = 2'd1,
    TAG_WRITE = 2'd2,
    TAG_EXEC  = 2'd3
  } tag_e;

  // bits a request needs to find set in the protection word
  function automatic logic [PTE_W-1:0] need_mask(input logic [1:0] mode,
                                                  input logic instr,
                                                  input logic wr);
    logic [PTE_W-1:0] m;
    m = '0;
    m[B_VALID] = 1'b1;
    if (instr) begin
      m[B_XOK] = 1'b1;
      m[B_RE0 + int'(mode)] = 1'b1;
    end else if (wr) begin
      m[B_WOK] = 1'b1;
      m[B_WE0 + int'(mode)] = 1'b1;
    end else begin
      m[B_ROK] = 1'b1;
      m[B_RE0 + int'(mode)] = 1'b1;
    end
    return m;
  endfunction

  // priority: mode enable, then permit flags, then valid
  function automatic fault_e classify(input logic [PTE_W-1:0] missing);
    if ((missing & ~SPECIAL_MASK) != '0) return FLT_ACV;
    if ((missing & PERMIT_MASK) != '0)   return FLT_FOX;
    if (missing[B_VALID])                return FLT_TNV;
    return FLT_NONE;
  endfunction

  function automatic tag_e stream_tag(input logic instr, input logic wr);
    if (instr) return TAG_EXEC;
    return wr ? TAG_WRITE : TAG_READ;
  endfunction

endpackage

// File: rtl/xlate_va_decode.sv
module xlate_va_decode #(
  parameter int VA_W     = 64,
  parameter int IMPL_W   = 43,
  parameter int SP32_KEEP = 30,
  parameter int SP43_SEL = 2
) (
  input  logic [VA_W-1:0]   va,
  input  logic              sp43_en,
  input  logic              sp32_en,
  output logic              sext_ok,
  output logic              sp43_hit,
  output logic              sp32_hit,
  output logic [IMPL_W-1:0] sp_pa
);
  localparam int SEXT_W  = VA_W - IMPL_W;
  localparam int SP32_FW = IMPL_W - SP32_KEEP;
  localparam logic [SP32_FW-1:0] SP32_SEL = {{(SP32_FW-1){1'b1}}, 1'b0};

  logic [SEXT_W-1:0]  sext_field;
  logic [1:0]         sp43_field;
  logic [SP32_FW-1:0] sp32_field;

  assign sext_field = va[VA_W-1:IMPL_W];
  assign sp43_field = va[IMPL_W-1:IMPL_W-2];
  assign sp32_field = va[IMPL_W-1:SP32_KEEP];

  assign sext_ok  = (sext_field == '0) || (sext_field == '1);
  assign sp43_hit = sp43_en && (sp43_field == 2'(SP43_SEL));
  assign sp32_hit = sp32_en && (sp32_field == SP32_SEL);

  // 43-bit window checked first
  always_comb begin
    if (sp43_hit) sp_pa = va[IMPL_W-1:0];
    else          sp_pa = {{SP32_FW{1'b0}}, va[SP32_KEEP-1:0]};
  end
endmodule

// File: rtl/xlate_perm_check.sv
module xlate_perm_check
  import xlate_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic             instr,
  input  logic             wr,
  input  logic [PTE_W-1:0] pte,
  output logic [PTE_W-1:0] need_bits,
  output logic [PTE_W-1:0] miss_bits,
  output fault_e           perm_fault
);
  assign need_bits  = need_mask(mode, instr, wr);
  assign miss_bits  = need_bits & ~pte;
  assign perm_fault = classify(miss_bits);
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int IMPL_W    = 43,
  parameter int PG_W      = 13,
  parameter int SP32_KEEP = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_va,
  input  logic                 req_instr,
  input  logic                 req_write,
  input  logic [1:0]           req_mode,
  input  logic                 sp43_en,
  input  logic                 sp32_en,
  input  logic                 tlb_hit,
  input  logic [IMPL_W-PG_W-1:0] tlb_pfn,
  input  logic [15:0]          tlb_pte,
  output logic                 rsp_valid,
  output logic [IMPL_W-1:0]    rsp_pa,
  output logic [2:0]           rsp_fault,
  output logic [1:0]           rsp_tag
);
  localparam logic [1:0] MODE_KERNEL = 2'd0;

  logic              sext_ok, sp43_hit, sp32_hit, sp_any;
  logic [IMPL_W-1:0] sp_pa, tlb_pa;
  logic [PTE_W-1:0]  need_bits, miss_bits;
  fault_e            perm_fault, nxt_fault;
  logic [IMPL_W-1:0] nxt_pa;

  xlate_va_decode #(
    .VA_W(VA_W), .IMPL_W(IMPL_W), .SP32_KEEP(SP32_KEEP), .SP43_SEL(2)
  ) u_dec (
    .va(req_va), .sp43_en(sp43_en), .sp32_en(sp32_en),
    .sext_ok(sext_ok), .sp43_hit(sp43_hit), .sp32_hit(sp32_hit), .sp_pa(sp_pa)
  );

  xlate_perm_check u_perm (
    .mode(req_mode), .instr(req_instr), .wr(req_write), .pte(tlb_pte),
    .need_bits(need_bits), .miss_bits(miss_bits), .perm_fault(perm_fault)
  );

  assign sp_any = sp43_hit || sp32_hit;
  assign tlb_pa = {tlb_pfn, req_va[PG_W-1:0]};

  always_comb begin
    nxt_fault = FLT_NONE;
    nxt_pa    = '0;
    if (!sext_ok) begin
      nxt_fault = FLT_BVA;
    end else if (sp_any) begin
      if (req_mode != MODE_KERNEL) nxt_fault = FLT_ACV;
      else                         nxt_pa = sp_pa;
    end else if (!tlb_hit) begin
      nxt_fault = FLT_TBM;
    end else if (perm_fault != FLT_NONE) begin
      nxt_fault = perm_fault;
    end else begin
      nxt_pa = tlb_pa;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa    <= nxt_pa;
        rsp_fault <= nxt_fault;
        rsp_tag   <= (nxt_fault == FLT_NONE) ? TAG_NONE
                                             : stream_tag(req_instr, req_write);
      end else begin
        rsp_pa    <= '0;
        rsp_fault <= '0;
        rsp_tag   <= '0;
      end
    end
  end
endmodule

// File: rtl/xlate_unit_chk.sv
module xlate_unit_chk #(
  parameter int IMPL_W = 43
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_mode,
  input logic              sext_ok,
  input logic              sp43_hit,
  input logic              sp32_hit,
  input logic              tlb_hit,
  input logic              rsp_valid,
  input logic [IMPL_W-1:0] rsp_pa,
  input logic [2:0]        rsp_fault,
  input logic [1:0]        rsp_tag
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bva_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sext_ok) |=> (rsp_fault == 3'd1));
  assert_sp_kernel_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sext_ok && (sp43_hit || sp32_hit) && req_mode != 2'd0)
      |=> (rsp_fault == 3'd2));
  assert_miss_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sext_ok && !sp43_hit && !sp32_hit && !tlb_hit)
      |=> (rsp_fault == 3'd3));
  assert_fault_zero_pa_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 3'd0) |-> (rsp_pa == '0 && rsp_tag != 2'd0));
  assert_clean_no_tag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd0) |-> (rsp_tag == 2'd0));
endmodule

bind xlate_unit xlate_unit_chk #(.IMPL_W(IMPL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .sext_ok(sext_ok), .sp43_hit(sp43_hit), .sp32_hit(sp32_hit),
  .tlb_hit(tlb_hit), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
  .rsp_fault(rsp_fault), .rsp_tag(rsp_tag)
);

// File: tb/xlate_unit_tb.sv
module xlate_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_instr = 1'b0, req_write = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        sp43_en = 1'b0, sp32_en = 1'b0, tlb_hit = 1'b0;
  logic [29:0] tlb_pfn = '0;
  logic [15:0] tlb_pte = '0;
  logic        rsp_valid;
  logic [42:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [1:0]  rsp_tag;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_instr(req_instr), .req_write(req_write), .req_mode(req_mode),
    .sp43_en(sp43_en), .sp32_en(sp32_en), .tlb_hit(tlb_hit),
    .tlb_pfn(tlb_pfn), .tlb_pte(tlb_pte), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_tag(rsp_tag)
  );

  // behavioural reference: returns {valid, fault, tag, pa}
  function automatic logic [48:0] model(input bit v);
    int fault;
    int tag;
    logic [42:0] pa;
    int en_bit;
    int ok_bit;
    fault = 0; pa = '0;
    if (!v) return '0;
    if (!(req_va[63:43] == 21'h0 || req_va[63:43] == 21'h1FFFFF)) fault = 1;
    else if (sp43_en && req_va[42:41] == 2'b10) begin
      if (req_mode != 0) fault = 2; else pa = req_va[42:0];
    end else if (sp32_en && req_va[42:30] == 13'h1FFE) begin
      if (req_mode != 0) fault = 2; else pa = {13'h0, req_va[29:0]};
    end else if (!tlb_hit) fault = 3;
    else begin
      en_bit = (!req_instr && req_write) ? 12 + req_mode : 8 + req_mode;
      ok_bit = req_instr ? 3 : (req_write ? 2 : 1);
      if (!tlb_pte[en_bit]) fault = 2;
      else if (!tlb_pte[ok_bit]) fault = 4;
      else if (!tlb_pte[0]) fault = 5;
      else pa = {tlb_pfn, req_va[12:0]};
    end
    if (fault == 0) tag = 0;
    else tag = req_instr ? 3 : (req_write ? 2 : 1);
    return {1'b1, 3'(fault), 2'(tag), pa};
  endfunction

  task automatic step(input string rq, input bit v);
    logic [48:0] exp;
    @(negedge clk);
    req_valid = v;
    exp = model(v);
    @(posedge clk);
    #(CLK_PERIOD/4);
    n_checks++;
    if ({rsp_valid, rsp_fault, rsp_tag, rsp_pa} !== exp) begin
      n_fail++;
      $display("FAIL %s: got v=%0d f=%0d t=%0d pa=%h exp v=%0d f=%0d t=%0d pa=%h",
               rq, rsp_valid, rsp_fault, rsp_tag, rsp_pa,
               exp[48], exp[47:45], exp[44:43], exp[42:0]);
    end
  endtask

  task automatic setreq(input logic [63:0] va, input logic ins, input logic wr,
                        input logic [1:0] md, input logic e43, input logic e32,
                        input logic hit, input logic [29:0] pfn, input logic [15:0] pte);
    @(negedge clk);
    req_va = va; req_instr = ins; req_write = wr; req_mode = md;
    sp43_en = e43; sp32_en = e32; tlb_hit = hit; tlb_pfn = pfn; tlb_pte = pte;
  endtask

  localparam logic [15:0] ALL_OK = 16'hFF0F;

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    n_checks++;
    if ({rsp_valid, rsp_fault, rsp_tag, rsp_pa} !== '0) begin
      n_fail++;
      $display("FAIL R1: got %h exp 0", {rsp_valid, rsp_fault, rsp_tag, rsp_pa});
    end
    @(negedge clk); rst_n = 1'b1;
    step("R1 idle", 0);
    step("R2 idle", 0);
    // R3: bad sign extension overrides superpage and hit
    setreq({21'h000100, 2'b10, 41'h123}, 0, 0, 0, 1, 1, 1, 30'h1, ALL_OK);
    step("R3", 1);
    setreq({21'h1FFFFE, 43'h0}, 1, 0, 0, 0, 0, 1, 30'h1, ALL_OK);
    step("R3 ones", 1);
    // R4: 43-bit window, kernel, miss ignored
    setreq({21'h1FFFFF, 2'b10, 41'h0_1234_5678}, 0, 0, 0, 1, 0, 0, 30'h0, 16'h0);
    step("R4", 1);
    setreq({21'h1FFFFF, 2'b10, 41'h0_1234_5678}, 0, 0, 0, 0, 0, 0, 30'h0, 16'h0);
    step("R4 disabled R7", 1);
    // R6
    setreq({21'h1FFFFF, 2'b10, 41'h77}, 0, 1, 3, 1, 0, 1, 30'h5, ALL_OK);
    step("R6 sp43 user", 1);
    // R5
    setreq({21'h0, 13'h1FFE, 30'h2345_678}, 0, 1, 0, 0, 1, 0, 30'h0, 16'h0);
    step("R5", 1);
    setreq({21'h0, 13'h1FFE, 30'h2345_678}, 1, 0, 2, 0, 1, 1, 30'h3, ALL_OK);
    step("R6 sp32 super", 1);
    setreq({21'h0, 13'h1FFF, 30'h11}, 0, 0, 0, 0, 1, 0, 30'h3, ALL_OK);
    step("R7 outside sp32", 1);
    // R8
    setreq({21'h0, 22'h12345, 8'h00, 13'h1ABC}, 0, 0, 0, 0, 0, 1, 30'h2ABC_DEF0, ALL_OK);
    step("R8", 1);
    // R9: user read enable missing, valid also clear
    setreq({21'h0, 43'h4000}, 0, 0, 3, 0, 0, 1, 30'h9, 16'hF70E);
    step("R9", 1);
    // R9: write uses write enable (kernel WE clear, RE set)
    setreq({21'h0, 43'h4000}, 0, 1, 0, 0, 0, 1, 30'h9, 16'hEF0F);
    step("R9 write", 1);
    // R10: write-permit clear, valid clear too
    setreq({21'h0, 43'h6000}, 0, 1, 1, 0, 0, 1, 30'h9, 16'hFF0A);
    step("R10 R12 write", 1);
    // R10 fetch: execute-permit clear
    setreq({21'h0, 43'h6000}, 1, 1, 2, 0, 0, 1, 30'h9, 16'hFF07);
    step("R10 R12 exec", 1);
    // R11
    setreq({21'h0, 43'h8000}, 0, 0, 2, 0, 0, 1, 30'h9, 16'hFF0E);
    step("R11 R12 read", 1);
    // fetch uses read enable: write enables clear
    setreq({21'h0, 43'h8123}, 1, 1, 1, 0, 0, 1, 30'h3FFF_FFFF, 16'h0F0F);
    step("R9 R12 exec ok", 1);
    step("R2 drop", 0);
    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [63:0] va;
      va = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: va[63:43] = '0;
        1: va[63:43] = '1;
        default: ;
      endcase
      if ($urandom_range(0, 3) == 0) va[42:41] = 2'b10;
      if ($urandom_range(0, 3) == 0) va[42:30] = 13'h1FFE;
      setreq(va, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
             1'($urandom), ($urandom_range(0, 4) != 0), 30'($urandom),
             16'($urandom) | (($urandom_range(0, 1) == 1) ? 16'hFF0F : 16'h0));
      step("R2-R12 random", ($urandom_range(0, 5) != 0));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule